// File: doc/BRIEF.md
# Phase-Staggered Four-Channel PWM Generator

This block produces a set of internally generated PWM signals that drive bridge control logic. All channels share a single free-running period counter of 512 counts; with the intended 16 MHz clock this gives a 32 µs period, close to a 31.25 kHz carrier. Each channel's high time is set by a 9-bit duty code in counter steps, so the resolution is one count out of 512.

The channels do not start their periods together. Channel n treats counter value n*128 as its own period origin, so the rising edges of the four outputs are spread a quarter period apart and the peak supply current is reduced. Duty codes arrive through a simple write port, one channel per write. Each write lands in a shadow register. The shadow is copied into the working register only as that channel's own period begins, so a channel never emits a shortened or extra pulse. A separate full-on flag, written with the duty code, holds the output high for the whole period.

Top module: `pwm_stagger_gen`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, every output is low; all working and shadow duty codes reset to 0 with the full-on flag clear.
- R2: The shared counter starts at 0 after reset and steps by one each clock, wrapping from 511 to 0. A channel with working code D (1..510, full-on clear) is high for exactly D consecutive counts of each 512-count period.
- R3: Channel n (n = 0..3) has its local phase equal to (counter − n*128) mod 512. Its high time starts at local phase 0, so with a non-zero code it is high exactly in the cycles where local phase < D.
- R4: A working code of 0 with full-on clear keeps the channel low for the whole period.
- R5: A working code of 511 with full-on clear makes the channel high for local phases 0..510 and low at local phase 511.
- R6: With the full-on flag set, the channel is high at every count, whatever its duty code.
- R7: A write (wr_en high on a rising edge, wr_ch = channel index, wr_duty = code, wr_full = flag) changes only the shadow. The working code and flag are replaced by the shadow at the clock edge that ends local phase 511, so the current period of that channel keeps its old duty.
- R8: A write to one channel leaves the outputs of every other channel unchanged.
- R9: A write on the same edge that ends a channel's local phase 511 takes effect one period later; the period that begins at that edge still uses the shadow value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one counter step per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Duty write strobe, sampled on the rising edge |
| wr_ch | input | 2 | Index of the channel to write |
| wr_duty | input | 9 | Duty code in counter counts |
| wr_full | input | 1 | Full-on flag for the written channel |
| pwm_o | output | 4 | PWM outputs, bit n is channel n |

## Verification
Each output is registered, so after a rising edge the output shows the level for the counter value that edge loaded. The level is a function of that counter value and the channel's working code. A write reaches the shadow at its edge, but no output reacts until the edge that ends the channel's local phase 511. The next period's first level therefore appears one edge after the write at the earliest. The bench keeps its own count of edges since reset and its own shadow and working copies, updated right after each rising edge in that same order. It compares all four outputs at every falling edge, so each result is checked in the same cycle it becomes due.

// File: rtl/pwm_stagger_pkg.sv
package pwm_stagger_pkg;
   // default geometry: 4 channels, 9-bit counter (512 counts per period)
   localparam int unsigned PWM_NUM_CH_DEF = 4;
   localparam int unsigned PWM_CNT_W_DEF  = 9;

   // width of a channel index, at least one bit
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter #(
   parameter int unsigned CNT_W = pwm_stagger_pkg::PWM_CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   initial begin
      if (CNT_W < 2) $error("CNT_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R2: counter wraps from the top count to zero
   a_r2_cnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '1) |=> (cnt_q == '0));

   // R2: counter advances by exactly one elsewhere
   a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '1) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/pwm_stagger_channel.sv
module pwm_stagger_channel #(
   parameter int unsigned CNT_W  = pwm_stagger_pkg::PWM_CNT_W_DEF,
   parameter int unsigned OFFSET = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_duty_i,
   input  logic             wr_full_i,
   output logic             pwm_o
);
   localparam int unsigned PERIOD = 1 << CNT_W;

   logic [CNT_W-1:0] phase, phase_nxt;
   logic [CNT_W-1:0] sh_duty, ac_duty, duty_nxt;
   logic             sh_full, ac_full, full_nxt;
   logic             at_end;
   logic             pwm_q;

   initial begin
      if (OFFSET >= PERIOD) $error("OFFSET must lie inside one period");
   end

   // local phase of this channel relative to the shared counter
   assign phase     = cnt_i - CNT_W'(OFFSET);
   assign at_end    = (phase == '1);
   assign phase_nxt = phase + 1'b1;

   // at the period boundary the shadow becomes the working value
   assign duty_nxt = at_end ? sh_duty : ac_duty;
   assign full_nxt = at_end ? sh_full : ac_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_duty <= '0;
         sh_full <= 1'b0;
         ac_duty <= '0;
         ac_full <= 1'b0;
         pwm_q   <= 1'b0;
      end else begin
         if (at_end) begin
            ac_duty <= sh_duty;
            ac_full <= sh_full;
         end
         if (wr_i) begin
            sh_duty <= wr_duty_i;
            sh_full <= wr_full_i;
         end
         pwm_q <= full_nxt | (phase_nxt < duty_nxt);
      end
   end

   assign pwm_o = pwm_q;

   // R7: working duty only changes across the period boundary
   a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
      !at_end |=> ($stable(ac_duty) && $stable(ac_full)));

   // R5: last count of a period is low unless full-on
   a_r5_last_count_low: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && !ac_full) |-> !pwm_q);

   // R3: a non-zero duty starts high at local phase zero
   a_r3_start_high: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == '0) && ((ac_duty != '0) || ac_full)) |-> pwm_q);

   // R6: full-on keeps the output high
   a_r6_full_on_high: assert property (@(posedge clk) disable iff (!rst_n)
      ac_full |-> pwm_q);

   // R4: zero duty stays low
   a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((ac_duty == '0) && !ac_full) |-> !pwm_q);
endmodule

// File: rtl/pwm_stagger_gen.sv
module pwm_stagger_gen #(
   parameter int unsigned NUM_CH = pwm_stagger_pkg::PWM_NUM_CH_DEF,
   parameter int unsigned CNT_W  = pwm_stagger_pkg::PWM_CNT_W_DEF,
   localparam int unsigned SEL_W = pwm_stagger_pkg::idx_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_ch,
   input  logic [CNT_W-1:0]  wr_duty,
   input  logic              wr_full,
   output logic [NUM_CH-1:0] pwm_o
);
   localparam int unsigned PERIOD = 1 << CNT_W;
   localparam int unsigned STEP   = PERIOD / NUM_CH;

   logic [CNT_W-1:0] cnt;

   initial begin
      if (NUM_CH < 2)             $error("NUM_CH must be at least 2");
      if (NUM_CH > PERIOD)        $error("NUM_CH must not exceed the period");
      if ((PERIOD % NUM_CH) != 0) $error("period must split evenly across channels");
   end

   pwm_phase_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt_o (cnt)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic sel;
      assign sel = wr_en && (wr_ch == SEL_W'(g));

      pwm_stagger_channel #(
         .CNT_W  (CNT_W),
         .OFFSET (g * STEP)
      ) ch_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .cnt_i     (cnt),
         .wr_i      (sel),
         .wr_duty_i (wr_duty),
         .wr_full_i (wr_full),
         .pwm_o     (pwm_o[g])
      );
   end

   // R1: all outputs low in the first cycle after reset release
   a_r1_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pwm_o == '0));
endmodule

// File: tb/pwm_stagger_gen_tb_top.sv
module pwm_stagger_gen_tb_top;
   localparam int NCH = 4;
   localparam int PER = 512;
   localparam int QTR = PER / NCH;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_ch = '0;
   logic [8:0] wr_duty = '0;
   logic       wr_full = 1'b0;
   logic [3:0] pwm_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // bench-side model
   int  m_cnt;
   int  sh_d [NCH];
   bit  sh_f [NCH];
   int  ac_d [NCH];
   bit  ac_f [NCH];
   string ctx = "R2";

   always #10 clk = ~clk;   // 50 MHz

   pwm_stagger_gen dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_ch   (wr_ch),
      .wr_duty (wr_duty),
      .wr_full (wr_full),
      .pwm_o   (pwm_o)
   );

   function automatic int local_phase(int n);
      return (m_cnt - n * QTR + PER) % PER;
   endfunction

   function automatic bit exp_level(int n);
      return ac_f[n] || (local_phase(n) < ac_d[n]);
   endfunction

   function automatic string category(int n);
      if (ac_f[n])               return "R6";
      if (ac_d[n] == 0)          return "R4";
      if (ac_d[n] == 511)        return "R5";
      if (local_phase(n) == 0)   return "R3";
      return "R2";
   endfunction

   task automatic check_all();
      for (int n = 0; n < NCH; n++) begin
         total++;
         if (pwm_o[n] !== exp_level(n)) begin
            bad++;
            $display("FAIL %s/%s ch%0d cnt=%0d actual=%b expected=%b",
                     ctx, category(n), n, m_cnt, pwm_o[n], exp_level(n));
         end
      end
   endtask

   // one clock: drive at falling edge, model update after rising edge
   task automatic step(bit en, int ch, int d, bit f);
      wr_en   = en;
      wr_ch   = 2'(ch);
      wr_duty = 9'(d);
      wr_full = f;
      @(posedge clk);
      for (int n = 0; n < NCH; n++) begin
         if (local_phase(n) == PER - 1) begin
            ac_d[n] = sh_d[n];
            ac_f[n] = sh_f[n];
         end
      end
      if (en) begin
         sh_d[ch] = d;
         sh_f[ch] = f;
      end
      m_cnt = (m_cnt + 1) % PER;
      @(negedge clk);
      wr_en = 1'b0;
      check_all();
   endtask

   task automatic idle(int cycles);
      for (int i = 0; i < cycles; i++) step(0, 0, 0, 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_c0de));
      for (int n = 0; n < NCH; n++) begin
         sh_d[n] = 0; sh_f[n] = 0; ac_d[n] = 0; ac_f[n] = 0;
      end
      m_cnt = 0;
      repeat (4) @(negedge clk);
      // R1: outputs low while in reset
      total++;
      if (pwm_o !== 4'b0000) begin
         bad++;
         $display("FAIL R1 in reset actual=%b expected=0000", pwm_o);
      end
      rst_n = 1'b1;
      ctx = "R1";
      total++;
      if (pwm_o !== 4'b0000) begin
         bad++;
         $display("FAIL R1 after release actual=%b expected=0000", pwm_o);
      end
      idle(20);

      // directed corners: zero, top code, full-on, mid value
      ctx = "R2";
      step(1, 0, 0, 0);
      step(1, 1, 511, 0);
      step(1, 2, 37, 1);
      step(1, 3, 200, 0);
      idle(2 * PER);

      // R7: mid-period rewrite of channel 3 must wait for its boundary
      ctx = "R7";
      while (local_phase(3) != 50) idle(1);
      step(1, 3, 5, 0);
      idle(PER);

      // R8: rewrite channel 0 heavily, others must keep their pattern
      ctx = "R8";
      step(1, 0, 300, 0);
      idle(100);
      step(1, 0, 1, 0);
      idle(PER);

      // R9: write landing on the load edge of channel 1
      ctx = "R9";
      while (local_phase(1) != PER - 1) idle(1);
      step(1, 1, 64, 0);
      idle(2 * PER);

      // constrained random traffic
      ctx = "R2";
      for (int i = 0; i < 8 * PER; i++) begin
         if (($urandom % 40) == 0) begin
            int ch;
            int d;
            bit f;
            ch = int'($urandom % NCH);
            case ($urandom % 6)
               0: d = 0;
               1: d = 511;
               2: d = 1;
               default: d = int'($urandom % PER);
            endcase
            f = (($urandom % 8) == 0);
            step(1, ch, d, f);
         end else begin
            idle(1);
         end
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20ns * 200000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule